// File: doc/BRIEF.md
# Texel Miss Waiting Table

This block parks texture requests that could not be served straight from the texture cache. Along with each request it receives every texel address that the filter needs, the data of the texels that did hit, and a mask that marks those hits. The request takes the lowest free entry in the table. The texels that missed wait there until memory returns their blocks.

A returning block arrives on the fill port as a block address and its words. The block address is compared against every waiting texel in every entry in the same cycle. Each texel that matches takes its word and is marked ready, so one returning block can wake texels in many entries at once.

When every texel that an entry's filter mode needs is ready, the entry is offered on a valid/ready output stream to the filtering unit. It is freed when that transfer completes. When the table is full, the insert port deasserts its ready so the pipeline upstream stalls.

Top module: `texel_wait_table`

## Requirements
- R1: After reset the output stream is idle (`out_valid` low) and `ins_ready` is high.
- R2: A request whose needed texels all hit is offered on the output in the cycle after it is accepted. It carries the inserted ID, filter mode, filter information and texel data.
- R3: The filter mode sets which texel slots are needed. Code 0 (nearest) needs slot 0. Code 1 (bilinear) needs slots 0 to 3. Codes 2 and 3 (trilinear) need all eight slots. A slot that is not needed never holds back an entry, and its output data is the data that was inserted.
- R4: A fill with block address B makes every waiting, not-yet-ready needed texel ready, in every entry, when that texel's address with the low log2(WORDS) word-offset bits dropped equals B. The texel takes fill word number (address modulo WORDS), where word w sits at bits [w*DATA_W +: DATA_W] of `fill_data`.
- R5: A texel that is already ready, whether from a hit or an earlier fill, keeps its data when a later fill matches its block.
- R6: When several entries are ready and no offer is pending, the entry with the lowest index is offered first. Inserts always take the lowest free index.
- R7: While all ENTRIES entries are occupied, `ins_ready` is low and an asserted `ins_valid` is ignored: no entry is created and no output results from it.
- R8: Once offered, an entry stays on the output with unchanged ID and data until `out_ready` accepts it, even if lower-indexed entries become ready in the meantime.
- R9: When an insert and a fill for the same block happen in the same cycle, the fill also completes the matching missed texels of the newly inserted request.
- R10: An entry whose request has been transferred is freed and can take a new insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request present |
| ins_ready | output | 1 | Table has a free entry |
| ins_id | input | ID_W | Texture request ID |
| ins_mode | input | 2 | Filter mode code (0 nearest, 1 bilinear, 2/3 trilinear) |
| ins_filt | input | FILT_W | Filtering information, carried through unchanged |
| ins_addr | input | SLOTS*ADDR_W | Texel addresses, slot s at [s*ADDR_W +: ADDR_W] |
| ins_data | input | SLOTS*DATA_W | Texel data for hit slots |
| ins_hit | input | SLOTS | Per-slot cache hit mask |
| fill_valid | input | 1 | A memory block is returning |
| fill_blk | input | ADDR_W-log2(WORDS) | Block address of the returning block |
| fill_data | input | WORDS*DATA_W | Words of the returning block |
| out_valid | output | 1 | A complete request is offered |
| out_ready | input | 1 | Filtering unit accepts the request |
| out_id | output | ID_W | ID of the offered request |
| out_mode | output | 2 | Filter mode of the offered request |
| out_filt | output | FILT_W | Filtering information of the offered request |
| out_data | output | SLOTS*DATA_W | All texel data of the offered request |

## Verification
The bench builds the table with ENTRIES=4, ADDR_W=16, DATA_W=16 and 4-bit ID and filter fields, and keeps SLOTS=8 and WORDS=8. With only four entries, the full-table stall and the rejected insert are reached within a few requests. The narrow fields keep the expected texel words easy to compute. Keeping eight slots and eight words exercises all three filter modes and every word offset within a block.

// File: rtl/texel_wait_table.sv
module texel_wait_table #(
  parameter int ENTRIES = 32,
  parameter int SLOTS   = 8,
  parameter int WORDS   = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 8,
  parameter int FILT_W  = 8,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_valid,
  output logic                     ins_ready,
  input  logic [ID_W-1:0]          ins_id,
  input  logic [1:0]               ins_mode,
  input  logic [FILT_W-1:0]        ins_filt,
  input  logic [SLOTS*ADDR_W-1:0]  ins_addr,
  input  logic [SLOTS*DATA_W-1:0]  ins_data,
  input  logic [SLOTS-1:0]         ins_hit,
  input  logic                     fill_valid,
  input  logic [BLK_W-1:0]         fill_blk,
  input  logic [WORDS*DATA_W-1:0]  fill_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ID_W-1:0]          out_id,
  output logic [1:0]               out_mode,
  output logic [FILT_W-1:0]        out_filt,
  output logic [SLOTS*DATA_W-1:0]  out_data
);

  logic [ENTRIES-1:0] vld_q;
  logic [ID_W-1:0]    id_q   [ENTRIES];
  logic [1:0]         mode_q [ENTRIES];
  logic [FILT_W-1:0]  filt_q [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES][SLOTS];
  logic [DATA_W-1:0]  data_q [ENTRIES][SLOTS];
  logic [SLOTS-1:0]   rdy_q  [ENTRIES];

  logic               hold_q;
  logic [IDX_W-1:0]   hold_idx_q;

  function automatic logic [SLOTS-1:0] need_of(input logic [1:0] m);
    case (m)
      2'd0:    need_of = {{(SLOTS-1){1'b0}}, 1'b1};
      2'd1:    need_of = {SLOTS{1'b1}} >> (SLOTS - SLOTS/2);
      default: need_of = {SLOTS{1'b1}};
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] word_of(input logic [OFF_W-1:0] w);
    word_of = fill_data[int'(w)*DATA_W +: DATA_W];
  endfunction

  logic [ENTRIES-1:0] ent_rdy;
  logic [IDX_W-1:0]   free_idx, pick_idx, sel;
  logic               any_rdy;

  always_comb begin
    free_idx = '0;
    pick_idx = '0;
    any_rdy  = 1'b0;
    for (int e = ENTRIES-1; e >= 0; e--) begin
      ent_rdy[e] = vld_q[e] & (&rdy_q[e]);
      if (!vld_q[e]) free_idx = IDX_W'(e);
      if (ent_rdy[e]) begin
        pick_idx = IDX_W'(e);
        any_rdy  = 1'b1;
      end
    end
  end

  assign ins_ready = ~&vld_q;
  assign sel       = hold_q ? hold_idx_q : pick_idx;
  assign out_valid = hold_q | any_rdy;
  assign out_id    = id_q[sel];
  assign out_mode  = mode_q[sel];
  assign out_filt  = filt_q[sel];

  always_comb
    for (int s = 0; s < SLOTS; s++) out_data[s*DATA_W +: DATA_W] = data_q[sel][s];

  wire take = ins_valid & ins_ready;
  wire give = out_valid & out_ready;
  wire [SLOTS-1:0] ins_need = need_of(ins_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q      <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      if (give) vld_q[sel] <= 1'b0;
      if (take) vld_q[free_idx] <= 1'b1;
      if (give)           hold_q <= 1'b0;
      else if (out_valid) hold_q <= 1'b1;
      if (out_valid && !hold_q) hold_idx_q <= pick_idx;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++)
      for (int s = 0; s < SLOTS; s++)
        if (fill_valid && vld_q[e] && !rdy_q[e][s] &&
            addr_q[e][s][ADDR_W-1:OFF_W] == fill_blk) begin
          data_q[e][s] <= word_of(addr_q[e][s][OFF_W-1:0]);
          rdy_q[e][s]  <= 1'b1;
        end
    if (take) begin
      id_q[free_idx]   <= ins_id;
      mode_q[free_idx] <= ins_mode;
      filt_q[free_idx] <= ins_filt;
      for (int s = 0; s < SLOTS; s++) begin
        addr_q[free_idx][s] <= ins_addr[s*ADDR_W +: ADDR_W];
        if (!ins_hit[s] && ins_need[s] && fill_valid &&
            ins_addr[s*ADDR_W+OFF_W +: BLK_W] == fill_blk) begin
          data_q[free_idx][s] <= word_of(ins_addr[s*ADDR_W +: OFF_W]);
          rdy_q[free_idx][s]  <= 1'b1;
        end else begin
          data_q[free_idx][s] <= ins_data[s*DATA_W +: DATA_W];
          rdy_q[free_idx][s]  <= ins_hit[s] | ~ins_need[s];
        end
      end
    end
  end

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id) && $stable(out_data))); // R8

  AST_FULL_NO_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready && !give) |=> ($countones(vld_q) == $past($countones(vld_q)))); // R7

  AST_FREE_ON_GIVE: assert property (@(posedge clk) disable iff (!rst_n)
    give |=> !vld_q[$past(sel)]); // R10

  for (genvar e = 0; e < ENTRIES; e++) begin : g_sticky
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      AST_READY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q[e] && rdy_q[e][s] && !(give && sel == IDX_W'(e)))
          |=> (rdy_q[e][s] && $stable(data_q[e][s]))); // R5
    end
  end

endmodule

// File: tb/test_texel_wait_table.sv
`timescale 1ns/1ps
module test_texel_wait_table;
  localparam int ENTRIES = 4, SLOTS = 8, WORDS = 8, ADDR_W = 16, DATA_W = 16;
  localparam int ID_W = 4, FILT_W = 4, BLK_W = 13;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic                    ins_valid = 0, ins_ready;
  logic [ID_W-1:0]         ins_id = 0;
  logic [1:0]              ins_mode = 0;
  logic [FILT_W-1:0]       ins_filt = 0;
  logic [SLOTS*ADDR_W-1:0] ins_addr = 0;
  logic [SLOTS*DATA_W-1:0] ins_data = 0;
  logic [SLOTS-1:0]        ins_hit = 0;
  logic                    fill_valid = 0;
  logic [BLK_W-1:0]        fill_blk = 0;
  logic [WORDS*DATA_W-1:0] fill_data = 0;
  logic                    out_valid, out_ready = 1;
  logic [ID_W-1:0]         out_id;
  logic [1:0]              out_mode;
  logic [FILT_W-1:0]       out_filt;
  logic [SLOTS*DATA_W-1:0] out_data;

  texel_wait_table #(.ENTRIES(ENTRIES), .SLOTS(SLOTS), .WORDS(WORDS), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .ID_W(ID_W), .FILT_W(FILT_W)) i_texel_wait_table (
    .clk, .rst_n, .ins_valid, .ins_ready, .ins_id, .ins_mode, .ins_filt, .ins_addr,
    .ins_data, .ins_hit, .fill_valid, .fill_blk, .fill_data, .out_valid, .out_ready,
    .out_id, .out_mode, .out_filt, .out_data);

  typedef struct packed {
    logic [ID_W-1:0]         id;
    logic [1:0]              mode;
    logic [FILT_W-1:0]       filt;
    logic [SLOTS*DATA_W-1:0] data;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int tests = 0, fails = 0;

  function automatic logic [DATA_W-1:0] fw(input logic [BLK_W-1:0] b, input int w);
    return {b[7:0], 5'h15, 3'(w)};
  endfunction

  function automatic logic [DATA_W-1:0] hd(input logic [ID_W-1:0] id, input int s);
    return {4'hC, id, 5'h00, 3'(s)};
  endfunction

  function automatic logic [SLOTS*ADDR_W-1:0] addrs(input logic [BLK_W-1:0] a,
      input logic [BLK_W-1:0] b, input logic [SLOTS-1:0] use_b);
    for (int s = 0; s < SLOTS; s++) addrs[s*ADDR_W +: ADDR_W] = {use_b[s] ? b : a, 3'(s)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input item_t it, input string req);
    exp_q.push_back(it);
    tag_q.push_back(req);
  endtask

  // expected: hit or unneeded slots keep inserted data, needed misses take their block word
  task automatic ins(input logic [ID_W-1:0] id, input logic [1:0] mode, input logic [FILT_W-1:0] filt,
      input logic [SLOTS*ADDR_W-1:0] a, input logic [SLOTS-1:0] hit,
      input bit fv, input logic [BLK_W-1:0] fb, output item_t it);
    int need;
    need = (mode == 0) ? 1 : (mode == 1) ? 4 : 8;
    it.id = id; it.mode = mode; it.filt = filt;
    @(posedge clk); #1;
    ins_valid = 1; ins_id = id; ins_mode = mode; ins_filt = filt; ins_addr = a; ins_hit = hit;
    for (int s = 0; s < SLOTS; s++) begin
      ins_data[s*DATA_W +: DATA_W] = hd(id, s);
      if (hit[s] || s >= need) it.data[s*DATA_W +: DATA_W] = hd(id, s);
      else it.data[s*DATA_W +: DATA_W] = fw(a[s*ADDR_W+3 +: BLK_W], s);
    end
    fill_valid = fv; fill_blk = fb;
    for (int w = 0; w < WORDS; w++) fill_data[w*DATA_W +: DATA_W] = fw(fb, w);
    @(posedge clk); #1;
    ins_valid = 0; fill_valid = 0;
  endtask

  task automatic fill(input logic [BLK_W-1:0] b);
    @(posedge clk); #1;
    fill_valid = 1; fill_blk = b;
    for (int w = 0; w < WORDS; w++) fill_data[w*DATA_W +: DATA_W] = fw(b, w);
    @(posedge clk); #1;
    fill_valid = 0;
  endtask

  task automatic set_ready(input bit r);
    @(posedge clk); #1;
    out_ready = r;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7", int'(out_id), -1);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        tests++;
        if (out_id !== e.id || out_mode !== e.mode || out_filt !== e.filt || out_data !== e.data) begin
          fails++;
          $display("FAIL %s: actual id %0h data %h expected id %0h data %h",
                   t, out_id, out_data, e.id, e.data);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    item_t it, ia, ib, ic;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1", out_valid, 0);
    chk(ins_ready == 1, "R1", ins_ready, 1);

    // R2 R3: bilinear with unneeded upper slots missing; nearest with only slot 0 hit
    ins(4'h1, 2'd1, 4'h3, addrs(13'h001, 0, 0), 8'h0F, 0, 0, it); push(it, "R2");
    ins(4'h2, 2'd0, 4'h5, addrs(13'h002, 0, 0), 8'h01, 0, 0, it); push(it, "R3");
    wait_neg(4);
    // R3: trilinear with slot 7 missing waits
    ins(4'h3, 2'd2, 4'h7, addrs(13'h004, 13'h005, 8'h80), 8'h7F, 0, 0, it);
    wait_neg(3);
    chk(out_valid == 0, "R3", out_valid, 0);
    push(it, "R4");
    fill(13'h005);
    wait_neg(3);

    // R4 R5: one block wakes texels in two entries; hit texels in that block keep their data
    ins(4'h4, 2'd1, 4'h1, addrs(13'h010, 0, 0), 8'h09, 0, 0, ia);
    ins(4'h5, 2'd1, 4'h2, addrs(13'h010, 13'h011, 8'h08), 8'h06, 0, 0, ib);
    push(ia, "R4");
    fill(13'h010);
    wait_neg(3);
    chk(out_valid == 0, "R4", out_valid, 0);
    push(ib, "R5");
    fill(13'h011);
    wait_neg(3);

    // R6 R8: lowest index first, held offer stays
    set_ready(0);
    ins(4'h6, 2'd1, 4'h0, addrs(13'h020, 0, 0), 8'h0E, 0, 0, ia);
    ins(4'h7, 2'd1, 4'h0, addrs(13'h021, 0, 0), 8'h0E, 0, 0, ib);
    ins(4'h8, 2'd1, 4'h0, addrs(13'h020, 0, 0), 8'h0E, 0, 0, ic);
    fill(13'h020);
    @(negedge clk);
    chk(out_valid == 1 && out_id == 4'h6, "R6", int'(out_id), 6);
    wait_neg(3);
    chk(out_valid == 1 && out_id == 4'h6, "R8", int'(out_id), 6);
    fill(13'h021);
    @(negedge clk);
    chk(out_id == 4'h6 && out_data == ia.data, "R8", int'(out_id), 6);
    push(ia, "R8"); push(ib, "R6"); push(ic, "R6");
    set_ready(1);
    wait_neg(5);

    // R7 R10: fill the table, reject an insert, then reuse a freed entry
    set_ready(0);
    for (int k = 0; k < 4; k++) begin
      ins(4'(9 + k), 2'd0, 4'(k), addrs(13'h030, 0, 0), 8'h00, 0, 0, it);
      push(it, "R7");
    end
    @(negedge clk);
    chk(ins_ready == 0, "R7", ins_ready, 0);
    @(posedge clk); #1;
    ins_valid = 1; ins_id = 4'hF; ins_mode = 2'd0; ins_hit = 8'hFF;
    repeat (2) @(posedge clk);
    #1 ins_valid = 0;
    fill(13'h030);
    set_ready(1);
    wait_neg(10);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    chk(ins_ready == 1, "R10", ins_ready, 1);
    ins(4'hD, 2'd2, 4'h9, addrs(13'h033, 0, 0), 8'hFF, 0, 0, it); push(it, "R10");
    wait_neg(4);

    // R9: insert and fill of the same block together
    ins(4'hE, 2'd3, 4'hA, addrs(13'h040, 13'h002, 8'hF0), 8'hF0, 1, 13'h040, it);
    push(it, "R9");
    wait_neg(4);
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
    chk(out_valid == 0, "R10", out_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule